// File: doc/BRIEF.md
# TFT Panel Frame Timing Generator

This block produces the raster timing for a TFT panel from a pixel dot clock. A horizontal dot counter runs through every line and a line counter runs through every frame. Compares against programmed region limits give a vertical sync pulse, a horizontal sync pulse, and a data-enable qualifier that marks the visible pixels. The counter values leave the block together with the syncs, so a pixel fetch stage can address its source without counting again.

The vertical timing comes from a single 32-bit word. The word holds front porch, back porch, sync width and a vertical-to-horizontal sync delay, plus a guard bit that must be set. The active line count and the four horizontal segment lengths come in on their own inputs. A mode input selects a passive-panel frame with no vertical sync and no porches. Every configuration input is copied into shadow registers at reset and at each frame wrap. A change made mid-frame therefore takes effect at the first line of the next frame.

Each line starts at pixel 0 with a delay segment of VHDLY+1 dots. Vertical sync changes only at pixel 0, so the horizontal sync always rises VHDLY+1 dot clocks after a vertical sync edge.

Top module: `tft_frame_timer`

## Requirements
- R1: While `rst` is high at a clock edge, all outputs are 0 after that edge. The first edge with `rst` low shows `line_o`=0 and `pix_o`=0, and `pix_o`=1 on the edge after.
- R2: A line lasts (VHDLY+1)+(hpw+1)+hbp+(hact+1)+hfp dots. `pix_o` counts 0 up to that length minus 1, then wraps to 0 while `line_o` advances. `hsync_o` is high for the hpw+1 dots that start at pixel VHDLY+1.
- R3: VHDLY sits in `cfg_vtim[29:22]`. Every edge of `vsync_o` occurs at pixel 0. The next rising edge of `hsync_o` follows it by VHDLY+1 dot clocks.
- R4: VPW sits in `cfg_vtim[21:16]`. With the passive mode off, `vsync_o` is high during lines 0 to VPW, so it lasts VPW+1 lines.
- R5: VBP sits in `cfg_vtim[15:8]`. VBP idle lines follow the sync lines, and then `cfg_lines`+1 active lines follow.
- R6: VFP sits in `cfg_vtim[7:0]`. VFP idle lines follow the active lines, and then the frame restarts at line 0. A frame therefore lasts (VPW+1)+VBP+(`cfg_lines`+1)+VFP lines.
- R7: `de_o` is high only on active lines, and only for the hact+1 dots that start at pixel (VHDLY+1)+(hpw+1)+hbp. It is never high together with `hsync_o`.
- R8: A configuration change takes effect at the first line of the next frame. The current frame ends with its old timing.
- R9: With `cfg_stn`=1, VPW, VBP and VFP count as 0. `vsync_o` stays low, and a frame is only the `cfg_lines`+1 active lines.
- R10: `cfg_err_o` is 1 for a frame whose shadowed word has bit 31 at 0. It is also 1 when the passive mode is on and any of bits [29:0] is nonzero. Otherwise it is 0. It changes only when the counters show line 0, pixel 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_vtim | input | 32 | Vertical timing word (fields per R3 to R6, guard bit 31) |
| cfg_stn | input | 1 | Passive-panel mode: no vertical sync or porches |
| cfg_lines | input | LINE_W | Active lines minus one |
| cfg_hpw | input | HFW | Horizontal sync width minus one |
| cfg_hbp | input | HFW | Horizontal back porch in dots |
| cfg_hact | input | HFW | Active dots per line minus one |
| cfg_hfp | input | HFW | Horizontal front porch in dots |
| vsync_o | output | 1 | Vertical sync |
| hsync_o | output | 1 | Horizontal sync |
| de_o | output | 1 | Data enable, visible pixel |
| line_o | output | VCW | Line counter aligned with the syncs |
| pix_o | output | HCW | Dot counter aligned with the syncs |
| cfg_err_o | output | 1 | Configuration error for the current frame |

## Verification
The hardest case to reach from the ports is a configuration change that lands in the middle of a frame. The old frame must finish unchanged, and the new frame must start with the new sync width and the new line length. The stimulus waits until the line counter output shows an active line, and only then rewrites the sync width and the delay. It then measures the next vertical sync pulse and the next full frame period in dot clocks. The passive mode and the error flag are reached the same way, by switching settings at arbitrary points and checking only after a frame boundary has passed.

// File: rtl/tft_tim_pkg.sv
package tft_tim_pkg;
  localparam int CFG_W   = 32;
  localparam int VFP_LSB = 0;
  localparam int VFP_W   = 8;
  localparam int VBP_LSB = 8;
  localparam int VBP_W   = 8;
  localparam int VPW_LSB = 16;
  localparam int VPW_W   = 6;
  localparam int VHD_LSB = 22;
  localparam int VHD_W   = 8;
  localparam int KEY_BIT = 31;

  typedef struct packed {
    logic [VHD_W-1:0] vhd;
    logic [VPW_W-1:0] vpw;
    logic [VBP_W-1:0] vbp;
    logic [VFP_W-1:0] vfp;
    logic             key;
  } vfield_t;

  function automatic vfield_t unpack_vtim(input logic [CFG_W-1:0] w);
    vfield_t f;
    f.vhd = w[VHD_LSB +: VHD_W];
    f.vpw = w[VPW_LSB +: VPW_W];
    f.vbp = w[VBP_LSB +: VBP_W];
    f.vfp = w[VFP_LSB +: VFP_W];
    f.key = w[KEY_BIT];
    return f;
  endfunction
endpackage

// File: rtl/tft_shadow_cfg.sv
module tft_shadow_cfg
  import tft_tim_pkg::*;
#(
  parameter int HFW    = 10,
  parameter int LINE_W = 11,
  parameter int HCW    = 13,
  parameter int VCW    = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [CFG_W-1:0]  cfg_vtim,
  input  logic              cfg_stn,
  input  logic [LINE_W-1:0] cfg_lines,
  input  logic [HFW-1:0]    cfg_hpw,
  input  logic [HFW-1:0]    cfg_hbp,
  input  logic [HFW-1:0]    cfg_hact,
  input  logic [HFW-1:0]    cfg_hfp,
  output logic [HCW-1:0]    hs_start,
  output logic [HCW-1:0]    hs_end,
  output logic [HCW-1:0]    ha_start,
  output logic [HCW-1:0]    ha_end,
  output logic [HCW-1:0]    h_last,
  output logic [VCW-1:0]    vs_end,
  output logic [VCW-1:0]    va_start,
  output logic [VCW-1:0]    va_end,
  output logic [VCW-1:0]    v_last,
  output logic              stn_q,
  output logic              err
);
  vfield_t           sv;
  logic [LINE_W-1:0] s_lines;
  logic [HFW-1:0]    s_hpw, s_hbp, s_hact, s_hfp;

  always_ff @(posedge clk) begin
    if (rst || load) begin
      sv      <= unpack_vtim(cfg_vtim);
      stn_q   <= cfg_stn;
      s_lines <= cfg_lines;
      s_hpw   <= cfg_hpw;
      s_hbp   <= cfg_hbp;
      s_hact  <= cfg_hact;
      s_hfp   <= cfg_hfp;
    end
  end

  logic [VCW-1:0] v_sync_len, v_bp_len, v_fp_len;

  always_comb begin
    hs_start = HCW'(sv.vhd) + HCW'(1);
    hs_end   = hs_start + HCW'(s_hpw) + HCW'(1);
    ha_start = hs_end + HCW'(s_hbp);
    ha_end   = ha_start + HCW'(s_hact) + HCW'(1);
    h_last   = ha_end + HCW'(s_hfp) - HCW'(1);

    v_sync_len = stn_q ? '0 : VCW'(sv.vpw) + VCW'(1);
    v_bp_len   = stn_q ? '0 : VCW'(sv.vbp);
    v_fp_len   = stn_q ? '0 : VCW'(sv.vfp);
    vs_end     = v_sync_len;
    va_start   = vs_end + v_bp_len;
    va_end     = va_start + VCW'(s_lines) + VCW'(1);
    v_last     = va_end + v_fp_len - VCW'(1);

    err = !sv.key || (stn_q && ({sv.vhd, sv.vpw, sv.vbp, sv.vfp} != '0));
  end
endmodule

// File: rtl/tft_hcount.sv
module tft_hcount #(
  parameter int HCW = 13
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [HCW-1:0] last_idx,
  input  logic [HCW-1:0] hs_start,
  input  logic [HCW-1:0] hs_end,
  input  logic [HCW-1:0] ha_start,
  input  logic [HCW-1:0] ha_end,
  output logic [HCW-1:0] cnt,
  output logic           wrap,
  output logic           hsync_n,
  output logic           hact_n
);
  assign wrap = (cnt == last_idx);

  always_ff @(posedge clk) begin
    if (rst || wrap) cnt <= '0;
    else             cnt <= cnt + HCW'(1);
  end

  always_comb begin
    hsync_n = (cnt >= hs_start) && (cnt < hs_end);
    hact_n  = (cnt >= ha_start) && (cnt < ha_end);
  end
endmodule

// File: rtl/tft_vcount.sv
module tft_vcount #(
  parameter int VCW = 12
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           step,
  input  logic [VCW-1:0] last_idx,
  input  logic [VCW-1:0] vs_end,
  input  logic [VCW-1:0] va_start,
  input  logic [VCW-1:0] va_end,
  output logic [VCW-1:0] cnt,
  output logic           frame_end,
  output logic           vsync_n,
  output logic           vact_n
);
  assign frame_end = step && (cnt == last_idx);

  always_ff @(posedge clk) begin
    if (rst || frame_end) cnt <= '0;
    else if (step)        cnt <= cnt + VCW'(1);
  end

  always_comb begin
    vsync_n = (cnt < vs_end);
    vact_n  = (cnt >= va_start) && (cnt < va_end);
  end
endmodule

// File: rtl/tft_frame_timer.sv
module tft_frame_timer
  import tft_tim_pkg::*;
#(
  parameter  int HFW    = 10,
  parameter  int LINE_W = 11,
  localparam int HCW    = ((HFW > 8) ? HFW : 8) + 3,
  localparam int VCW    = ((LINE_W > 10) ? LINE_W : 10) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [31:0]       cfg_vtim,
  input  logic              cfg_stn,
  input  logic [LINE_W-1:0] cfg_lines,
  input  logic [HFW-1:0]    cfg_hpw,
  input  logic [HFW-1:0]    cfg_hbp,
  input  logic [HFW-1:0]    cfg_hact,
  input  logic [HFW-1:0]    cfg_hfp,
  output logic              vsync_o,
  output logic              hsync_o,
  output logic              de_o,
  output logic [VCW-1:0]    line_o,
  output logic [HCW-1:0]    pix_o,
  output logic              cfg_err_o
);
  logic [HCW-1:0] hs_start, hs_end, ha_start, ha_end, h_last, hcnt;
  logic [VCW-1:0] vs_end, va_start, va_end, v_last, vcnt;
  logic           sh_stn, sh_err, h_wrap, frame_end;
  logic           hsync_n, hact_n, vsync_n, vact_n;

  tft_shadow_cfg #(.HFW(HFW), .LINE_W(LINE_W), .HCW(HCW), .VCW(VCW)) u_shadow (
    .clk(clk), .rst(rst), .load(frame_end), .cfg_vtim(cfg_vtim), .cfg_stn(cfg_stn),
    .cfg_lines(cfg_lines), .cfg_hpw(cfg_hpw), .cfg_hbp(cfg_hbp), .cfg_hact(cfg_hact),
    .cfg_hfp(cfg_hfp), .hs_start(hs_start), .hs_end(hs_end), .ha_start(ha_start),
    .ha_end(ha_end), .h_last(h_last), .vs_end(vs_end), .va_start(va_start),
    .va_end(va_end), .v_last(v_last), .stn_q(sh_stn), .err(sh_err)
  );

  tft_hcount #(.HCW(HCW)) u_hcnt (
    .clk(clk), .rst(rst), .last_idx(h_last), .hs_start(hs_start), .hs_end(hs_end),
    .ha_start(ha_start), .ha_end(ha_end), .cnt(hcnt), .wrap(h_wrap),
    .hsync_n(hsync_n), .hact_n(hact_n)
  );

  tft_vcount #(.VCW(VCW)) u_vcnt (
    .clk(clk), .rst(rst), .step(h_wrap), .last_idx(v_last), .vs_end(vs_end),
    .va_start(va_start), .va_end(va_end), .cnt(vcnt), .frame_end(frame_end),
    .vsync_n(vsync_n), .vact_n(vact_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      vsync_o   <= 1'b0;
      hsync_o   <= 1'b0;
      de_o      <= 1'b0;
      line_o    <= '0;
      pix_o     <= '0;
      cfg_err_o <= 1'b0;
    end else begin
      vsync_o   <= vsync_n;
      hsync_o   <= hsync_n;
      de_o      <= hact_n && vact_n;
      line_o    <= vcnt;
      pix_o     <= hcnt;
      cfg_err_o <= sh_err;
    end
  end
endmodule

// File: rtl/tft_frame_timer_chk.sv
module tft_frame_timer_chk #(
  parameter int HCW = 13,
  parameter int VCW = 12
) (
  input logic           clk,
  input logic           rst,
  input logic           vsync_o,
  input logic           hsync_o,
  input logic           de_o,
  input logic [VCW-1:0] line_o,
  input logic [HCW-1:0] pix_o,
  input logic           cfg_err_o,
  input logic           stn_q
);
  logic rst_q;
  always_ff @(posedge clk) rst_q <= rst;

  always_ff @(posedge clk) begin
    if (rst_q) begin
      p_reset_quiet_r1: assert (!vsync_o && !hsync_o && !de_o && !cfg_err_o &&
                                line_o == '0 && pix_o == '0)
        else $error("outputs not cleared by reset");
    end
  end

  property pr_pix_step;
    @(posedge clk) disable iff (rst) (pix_o != '0) |-> (pix_o == $past(pix_o) + HCW'(1));
  endproperty
  p_pix_step_r2: assert property (pr_pix_step);

  property pr_vs_edge;
    @(posedge clk) disable iff (rst) !$stable(vsync_o) |-> (pix_o == '0);
  endproperty
  p_vs_edge_at_zero_r3: assert property (pr_vs_edge);

  property pr_line_step;
    @(posedge clk) disable iff (rst) !$stable(line_o) |-> (pix_o == '0);
  endproperty
  p_line_at_wrap_r5: assert property (pr_line_step);

  property pr_de_hs;
    @(posedge clk) disable iff (rst) de_o |-> !hsync_o;
  endproperty
  p_de_apart_hsync_r7: assert property (pr_de_hs);

  property pr_stn;
    @(posedge clk) disable iff (rst) stn_q |-> !vsync_o;
  endproperty
  p_no_vsync_stn_r9: assert property (pr_stn);

  property pr_err;
    @(posedge clk) disable iff (rst) !$stable(cfg_err_o) |-> (pix_o == '0 && line_o == '0);
  endproperty
  p_err_at_frame_r10: assert property (pr_err);
endmodule

bind tft_frame_timer tft_frame_timer_chk #(.HCW(HCW), .VCW(VCW)) u_chk (
  .clk(clk), .rst(rst), .vsync_o(vsync_o), .hsync_o(hsync_o), .de_o(de_o),
  .line_o(line_o), .pix_o(pix_o), .cfg_err_o(cfg_err_o), .stn_q(sh_stn)
);

// File: tb/tft_frame_timer_bench.sv
module tft_frame_timer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HFW = 10;
  localparam int LINE_W = 11;
  localparam int HCW = 13;
  localparam int VCW = 12;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [31:0]       cfg_vtim;
  logic              cfg_stn;
  logic [LINE_W-1:0] cfg_lines;
  logic [HFW-1:0]    cfg_hpw, cfg_hbp, cfg_hact, cfg_hfp;
  logic              vsync_o, hsync_o, de_o, cfg_err_o;
  logic [VCW-1:0]    line_o;
  logic [HCW-1:0]    pix_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tft_frame_timer #(.HFW(HFW), .LINE_W(LINE_W)) u_tft_frame_timer (
    .clk(clk), .rst(rst), .cfg_vtim(cfg_vtim), .cfg_stn(cfg_stn), .cfg_lines(cfg_lines),
    .cfg_hpw(cfg_hpw), .cfg_hbp(cfg_hbp), .cfg_hact(cfg_hact), .cfg_hfp(cfg_hfp),
    .vsync_o(vsync_o), .hsync_o(hsync_o), .de_o(de_o), .line_o(line_o),
    .pix_o(pix_o), .cfg_err_o(cfg_err_o)
  );

  function automatic logic [31:0] vword(int key, int vhd, int vpw, int vbp, int vfp);
    return (32'(key) << 31) | (32'(vhd) << 22) | (32'(vpw) << 16) | (32'(vbp) << 8) | 32'(vfp);
  endfunction

  // reference model state
  int mh = 0, mv = 0;
  int s_vfp, s_vbp, s_vpw, s_vhd, s_key, s_stn, s_lines, s_hpw, s_hbp, s_hact, s_hfp;
  bit started = 1'b0;
  bit e_vs, e_hs, e_de, e_err;
  int e_line, e_pix, e_d;

  task automatic load_model();
    s_vfp = int'(cfg_vtim[7:0]);   s_vbp = int'(cfg_vtim[15:8]);
    s_vpw = int'(cfg_vtim[21:16]); s_vhd = int'(cfg_vtim[29:22]);
    s_key = int'(cfg_vtim[31]);    s_stn = int'(cfg_stn);
    s_lines = int'(cfg_lines); s_hpw = int'(cfg_hpw); s_hbp = int'(cfg_hbp);
    s_hact = int'(cfg_hact);   s_hfp = int'(cfg_hfp);
  endtask

  always @(posedge clk) begin
    int d, hse, has, hae, htot, vse, vas, vae, vtot;
    started = 1'b1;
    if (rst) begin
      {e_vs, e_hs, e_de, e_err} = '0;
      e_line = 0; e_pix = 0; mh = 0; mv = 0;
      load_model();
    end else begin
      d = s_vhd + 1; hse = d + s_hpw + 1; has = hse + s_hbp;
      hae = has + s_hact + 1; htot = hae + s_hfp;
      vse = s_stn ? 0 : s_vpw + 1; vas = vse + (s_stn ? 0 : s_vbp);
      vae = vas + s_lines + 1; vtot = vae + (s_stn ? 0 : s_vfp);
      e_vs = (mv < vse);
      e_hs = (mh >= d) && (mh < hse);
      e_de = (mh >= has) && (mh < hae) && (mv >= vas) && (mv < vae);
      e_err = (s_key == 0) || (s_stn != 0 && (s_vfp + s_vbp + s_vpw + s_vhd) != 0);
      e_line = mv; e_pix = mh; e_d = d;
      if (mh == htot - 1) begin
        mh = 0;
        if (mv == vtot - 1) begin mv = 0; load_model(); end
        else mv = mv + 1;
      end else mh = mh + 1;
    end
  end

  // per-cycle comparison and sync-offset monitor
  int cyc = 0, vedge_cyc = -1, vedge_d = 0;
  bit prev_vs = 1'b0, prev_hs = 1'b0;

  always @(negedge clk) begin
    if (started && !done) begin
      cyc++;
      checks++;
      if (vsync_o !== e_vs) begin failures++; $display("FAIL R4 vsync act=%0b exp=%0b t=%0t", vsync_o, e_vs, $time); end
      else if (hsync_o !== e_hs) begin failures++; $display("FAIL R2 hsync act=%0b exp=%0b t=%0t", hsync_o, e_hs, $time); end
      else if (de_o !== e_de) begin failures++; $display("FAIL R7 de act=%0b exp=%0b t=%0t", de_o, e_de, $time); end
      else if (int'(line_o) != e_line) begin failures++; $display("FAIL R5 line act=%0d exp=%0d", line_o, e_line); end
      else if (int'(pix_o) != e_pix) begin failures++; $display("FAIL R2 pix act=%0d exp=%0d", pix_o, e_pix); end
      else if (cfg_err_o !== e_err) begin failures++; $display("FAIL R10 err act=%0b exp=%0b", cfg_err_o, e_err); end
      if (!rst) begin
        if (vsync_o != prev_vs) begin vedge_cyc = cyc; vedge_d = e_d; end
        if (hsync_o && !prev_hs && vedge_cyc >= 0) begin
          checks++;
          if (cyc - vedge_cyc != vedge_d) begin
            failures++;
            $display("FAIL R3 hsync offset act=%0d exp=%0d", cyc - vedge_cyc, vedge_d);
          end
          vedge_cyc = -1;
        end
      end
      prev_vs = vsync_o; prev_hs = hsync_o;
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_vs_rise();
    @(negedge clk);
    while (vsync_o) @(negedge clk);
    while (!vsync_o) @(negedge clk);
  endtask

  task automatic vs_run(output int n);
    n = 0;
    wait_vs_rise();
    while (vsync_o) begin n++; @(negedge clk); end
  endtask

  task automatic frame_span(output int len, output int des);
    len = 0; des = 0;
    wait_vs_rise();
    do begin
      len++; if (de_o) des++;
      @(negedge clk);
    end while (!(vsync_o && !prev_vs));
  endtask

  initial begin
    int n, len, des;
    cfg_vtim = vword(1, 1, 1, 2, 2);
    cfg_stn = 1'b0; cfg_lines = 11'd3;
    cfg_hpw = 10'd1; cfg_hbp = 10'd2; cfg_hact = 10'd7; cfg_hfp = 10'd3;
    repeat (3) @(negedge clk);
    check("R1 reset outputs", int'({vsync_o, hsync_o, de_o, cfg_err_o}) + int'(line_o) + int'(pix_o), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 first line", int'(line_o), 0);
    check("R1 first pixel", int'(pix_o), 0);
    @(negedge clk);
    check("R1 second pixel", int'(pix_o), 1);

    // line 17 dots, frame 10 lines
    vs_run(n);
    check("R4 vsync run 2 lines", n, 2 * 17);
    frame_span(len, des);
    check("R6 frame period", len, 10 * 17);
    check("R5 R7 active dots per frame", des, 4 * 8);

    // mid-frame change of sync width and delay
    @(negedge clk);
    while (int'(line_o) != 5) @(negedge clk);
    cfg_vtim = vword(1, 4, 3, 2, 2);
    vs_run(n);
    check("R8 new vsync run", n, 4 * 20);
    frame_span(len, des);
    check("R8 R6 new frame period", len, 12 * 20);
    check("R7 active dots new frame", des, 4 * 8);

    // passive mode, fields zero
    cfg_vtim = vword(1, 0, 0, 0, 0);
    cfg_stn = 1'b1;
    repeat (300) @(negedge clk);
    n = 0; des = 0;
    for (int i = 0; i < 192; i++) begin
      if (vsync_o) n++;
      if (de_o) des++;
      @(negedge clk);
    end
    check("R9 no vsync", n, 0);
    check("R9 active only frames", des, 3 * 32);
    check("R10 passive clean no error", int'(cfg_err_o), 0);

    cfg_vtim = vword(1, 0, 0, 1, 0);
    repeat (300) @(negedge clk);
    check("R10 passive nonzero field", int'(cfg_err_o), 1);

    cfg_stn = 1'b0;
    cfg_vtim = vword(0, 1, 1, 2, 2);
    repeat (300) @(negedge clk);
    check("R10 guard bit clear", int'(cfg_err_o), 1);

    cfg_vtim = vword(1, 1, 1, 2, 2);
    repeat (300) @(negedge clk);
    check("R10 guard bit set", int'(cfg_err_o), 0);
    vs_run(n);
    check("R4 vsync run restored", n, 2 * 17);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1'b1;
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule